// File: doc/BRIEF.md
# Overlapped Message Block Input Buffer

This buffer sits between a 64-bit word bus and a hash permutation core. It gathers a 1024-bit message block as sixteen 64-bit words, one word per clock at most. While it does this, the core can still be absorbing and permuting the previous block. When the block is complete and the core reports idle, the whole block is presented to the core in a single cycle, marked by a one-cycle transfer strobe. The core captures the block on that edge. In the same cycle the buffer may already accept the first word of the next block.

The same block can also be placed in output mode. In that mode it stops taking bus words and keeps any partially collected block as it is. It then serves the 256-bit digest back to the bus as four 64-bit lanes through a read port.

Top module: `wordblock_buffer`

## Requirements
- R1: While reset is asserted and right after it, the block-full flag, the transfer strobe and the read pointer are zero. The handoff bus is all zeros. In input mode the write-ready output is high.
- R2: The k-th accepted word of a block (k = 0..15) appears in bits [64k+63:64k] of the 1024-bit handoff bus, starting in the cycle after it is accepted.
- R3: A word is accepted on any clock where write-valid and write-ready are both high. The 16th accepted word of a block sets the block-full flag in the next cycle.
- R4: While the block is full and the core is not idle, write-ready is low. Words offered on the bus then leave the handoff bus unchanged.
- R5: The transfer strobe is high in exactly the cycles where the block is full and the core-idle input is high, in either mode. The block-full flag is clear in the following cycle, unless a new block has been completed in the meantime.
- R6: In a handoff cycle in input mode, write-ready is high. A word written in that cycle becomes word 0 of the next block. The handoff bus still shows the completed block during the handoff cycle.
- R7: In output mode (mode input = 1), write-ready is low and offered words are ignored. A partially collected block is kept, and collection resumes at the next word index on return to input mode (mode input = 0).
- R8: In output mode the read-valid output is high and the read data is lane p of the 256-bit digest input (lane j = bits [64j+63:64j]), where p is the read pointer. Each read enable advances p, wrapping from 3 back to 0. In input mode p returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_mode_i | input | 1 | 0 = collect words from the bus, 1 = serve digest lanes |
| wr_valid_i | input | 1 | Bus word is offered |
| wr_data_i | input | 64 | Bus word |
| wr_ready_o | output | 1 | Buffer takes the offered word this cycle |
| blk_full_o | output | 1 | A complete block is waiting for the core |
| core_idle_i | input | 1 | Core can take a block this cycle |
| blk_xfer_o | output | 1 | One-cycle handoff strobe towards the core |
| blk_data_o | output | 1024 | Collected block, word k at bits [64k+63:64k] |
| dig_i | input | 256 | Digest lanes from the core |
| rd_en_i | input | 1 | Advance to the next digest lane |
| rd_valid_o | output | 1 | Read data is a valid digest lane |
| rd_data_o | output | 64 | Digest lane at the read pointer |

## Verification
The block is driven with four kinds of input. The first is unbroken back-to-back streaming with the core always idle; this shows whether word 0 of a block really overlaps the handoff of the previous one. The second is streaming against a busy core, which separates a correct stall from silent overwriting of the waiting block. The third is bursty offers with gaps, which show whether the counter moves only on real acceptances. The last is a switch to output mode halfway through a block, with reads that wrap the lane pointer; this tells apart a kept partial block from a lost or shifted one. A bench model of word placement is compared against the whole handoff bus every cycle.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic {
    MODE_COLLECT = 1'b0,
    MODE_SERVE   = 1'b1
  } buf_mode_e;
endpackage

// File: rtl/wbuf_wr_ctrl.sv
module wbuf_wr_ctrl
  import wbuf_pkg::*;
#(
  parameter int NWORDS = 16,
  localparam int IDX_W = $clog2(NWORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             out_mode_i,
  input  logic             wr_valid_i,
  input  logic             core_idle_i,
  output logic             wr_ready_o,
  output logic             accept_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             full_o,
  output logic             xfer_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic             full_q, full_d;
  logic             collecting;

  assign collecting = (buf_mode_e'(out_mode_i) == MODE_COLLECT);
  assign xfer_o     = full_q & core_idle_i;
  assign wr_ready_o = collecting & (~full_q | core_idle_i);
  assign accept_o   = wr_valid_i & wr_ready_o;
  assign wr_idx_o   = idx_q;
  assign full_o     = full_q;

  always_comb begin
    idx_d  = idx_q;
    full_d = full_q;
    if (xfer_o) full_d = 1'b0;
    if (accept_o) begin
      if (idx_q == LAST) begin
        idx_d  = '0;
        full_d = 1'b1;
      end else begin
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      full_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      full_q <= full_d;
    end
  end

  p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !core_idle_i) |-> !wr_ready_o);
  p_full_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_o && idx_q == LAST) |=> full_o);
  p_xfer_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_o |=> !full_o);
  p_serve_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_mode_i |-> !accept_o);
  p_serve_keeps_idx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_mode_i |=> $stable(idx_q));
endmodule

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int WORD_W = 64,
  parameter int NWORDS = 16,
  localparam int IDX_W = $clog2(NWORDS),
  localparam int BLK_W = WORD_W * NWORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [BLK_W-1:0]  blk_o
);
  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic              en;
    logic [WORD_W-1:0] word_q;
    assign en = accept_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q <= '0;
      else if (en) word_q <= wr_data_i;
    end
    assign blk_o[g*WORD_W +: WORD_W] = word_q;
  end

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_i |=> $stable(blk_o));
  p_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> blk_o[$past(wr_idx_i)*WORD_W +: WORD_W] == $past(wr_data_i));
endmodule

// File: rtl/wbuf_rd_port.sv
module wbuf_rd_port
  import wbuf_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int NLANES = 4,
  localparam int PTR_W = $clog2(NLANES),
  localparam int DIG_W = WORD_W * NLANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_mode_i,
  input  logic              rd_en_i,
  input  logic [DIG_W-1:0]  dig_i,
  output logic              rd_valid_o,
  output logic [WORD_W-1:0] rd_data_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NLANES - 1);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             serving;

  assign serving    = (buf_mode_e'(out_mode_i) == MODE_SERVE);
  assign rd_valid_o = serving;
  assign rd_data_o  = dig_i[ptr_q*WORD_W +: WORD_W];

  always_comb begin
    ptr_d = ptr_q;
    if (!serving)     ptr_d = '0;
    else if (rd_en_i) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (serving && rd_en_i && ptr_q == LAST) |=> ptr_q == '0);
  p_collect_rewinds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !serving |=> ptr_q == '0);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (serving && !rd_en_i) |=> $stable(ptr_q));
endmodule

// File: rtl/wordblock_buffer.sv
module wordblock_buffer #(
  parameter int WORD_W = 64,
  parameter int NWORDS = 16,
  parameter int NLANES = 4,
  localparam int IDX_W = $clog2(NWORDS),
  localparam int BLK_W = WORD_W * NWORDS,
  localparam int DIG_W = WORD_W * NLANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_mode_i,
  input  logic              wr_valid_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              wr_ready_o,
  output logic              blk_full_o,
  input  logic              core_idle_i,
  output logic              blk_xfer_o,
  output logic [BLK_W-1:0]  blk_data_o,
  input  logic [DIG_W-1:0]  dig_i,
  input  logic              rd_en_i,
  output logic              rd_valid_o,
  output logic [WORD_W-1:0] rd_data_o
);
  logic             accept;
  logic [IDX_W-1:0] wr_idx;

  wbuf_wr_ctrl #(.NWORDS(NWORDS)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_mode_i (out_mode_i),
    .wr_valid_i (wr_valid_i),
    .core_idle_i(core_idle_i),
    .wr_ready_o (wr_ready_o),
    .accept_o   (accept),
    .wr_idx_o   (wr_idx),
    .full_o     (blk_full_o),
    .xfer_o     (blk_xfer_o)
  );

  wbuf_store #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .wr_idx_i (wr_idx),
    .wr_data_i(wr_data_i),
    .blk_o    (blk_data_o)
  );

  wbuf_rd_port #(.WORD_W(WORD_W), .NLANES(NLANES)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_mode_i(out_mode_i),
    .rd_en_i   (rd_en_i),
    .dig_i     (dig_i),
    .rd_valid_o(rd_valid_o),
    .rd_data_o (rd_data_o)
  );

  p_xfer_needs_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    blk_xfer_o |-> (blk_full_o && core_idle_i));
  p_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_xfer_o && !out_mode_i) |-> wr_ready_o);
endmodule

// File: tb/wordblock_buffer_bench.sv
module wordblock_buffer_bench;
  localparam int W = 64, N = 16, L = 4;
  localparam int BW = W * N, DW = W * L;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          out_mode, wr_valid, core_idle, rd_en;
  logic [W-1:0]  wr_data;
  logic [DW-1:0] dig;
  logic          wr_ready, blk_full, blk_xfer, rd_valid;
  logic [BW-1:0] blk_data;
  logic [W-1:0]  rd_data;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [W-1:0] m_buf [N];
  int m_idx = 0, m_ptr = 0;
  bit m_full = 0;

  always #5 clk = ~clk;

  wordblock_buffer u_wordblock_buffer (
    .clk(clk), .rst_n(rst_n), .out_mode_i(out_mode), .wr_valid_i(wr_valid),
    .wr_data_i(wr_data), .wr_ready_o(wr_ready), .blk_full_o(blk_full),
    .core_idle_i(core_idle), .blk_xfer_o(blk_xfer), .blk_data_o(blk_data),
    .dig_i(dig), .rd_en_i(rd_en), .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  task automatic chk(bit ok, string tag, logic [BW-1:0] act, logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] model_blk();
    logic [BW-1:0] v;
    for (int k = 0; k < N; k++) v[k*W +: W] = m_buf[k];
    return v;
  endfunction

  function automatic logic [W-1:0] dat(int b, int k);
    return {16'hA5C3 ^ 16'(b), 16'(k), 32'(b * 1000 + k)};
  endfunction

  // one clock: drive at negedge, check outputs, update model, wait the edge
  task automatic step(bit v, logic [W-1:0] d, bit idle, bit mode, bit rd);
    bit e_rdy, e_xfer;
    @(negedge clk);
    wr_valid = v; wr_data = d; core_idle = idle; out_mode = mode; rd_en = rd;
    #1;
    e_rdy  = !mode && (!m_full || idle);
    e_xfer = m_full && idle;
    chk(wr_ready == e_rdy, mode ? "R7 ready" : "R4 ready", BW'(wr_ready), BW'(e_rdy));
    chk(blk_xfer == e_xfer, "R5 strobe", BW'(blk_xfer), BW'(e_xfer));
    chk(blk_full == m_full, "R3 full flag", BW'(blk_full), BW'(m_full));
    chk(blk_data == model_blk(), "R2 placement", blk_data, model_blk());
    if (e_xfer && !mode)
      chk(wr_ready == 1'b1, "R6 overlap ready", BW'(wr_ready), BW'(1));
    chk(rd_valid == mode, "R8 valid", BW'(rd_valid), BW'(mode));
    if (mode)
      chk(rd_data == dig[m_ptr*W +: W], "R8 lane", BW'(rd_data), BW'(dig[m_ptr*W +: W]));
    if (e_xfer) m_full = 0;
    if (v && e_rdy) begin
      m_buf[m_idx] = d;
      if (m_idx == N - 1) begin m_idx = 0; m_full = 1; end
      else m_idx++;
    end
    if (!mode) m_ptr = 0;
    else if (rd) m_ptr = (m_ptr + 1) % L;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) m_buf[k] = '0;
    for (int j = 0; j < L; j++) dig[j*W +: W] = 64'h1111_0000_0000_0000 * (j + 1) + 64'(j);
    rst_n = 0; out_mode = 0; wr_valid = 0; core_idle = 0; rd_en = 0; wr_data = '0;
    #12;
    // R1 reset values
    chk(blk_full == 0 && blk_xfer == 0, "R1 flags", BW'({blk_full, blk_xfer}), '0);
    chk(blk_data == '0, "R1 block", blk_data, '0);
    chk(wr_ready == 1, "R1 ready", BW'(wr_ready), BW'(1));
    @(negedge clk); rst_n = 1;

    // pattern A: busy core, fill, then stalled writes (R3, R4)
    for (int k = 0; k < N; k++) step(1, dat(1, k), 0, 0, 0);
    for (int k = 0; k < 3; k++) step(1, dat(9, k), 0, 0, 0);
    // handoff with word 0 of next block in same cycle (R5, R6)
    for (int b = 2; b < 5; b++)
      for (int k = 0; k < N; k++) step(1, dat(b, k), 1, 0, 0);
    step(0, '0, 1, 0, 0);  // last block handed off, no word offered
    step(0, '0, 1, 0, 0);

    // pattern B: bursty offers with gaps, core busy
    for (int k = 0; k < 2 * N; k++) step(k % 2 == 0, dat(5, k / 2), 0, 0, 0);
    step(0, '0, 1, 0, 0);

    // pattern C: partial block then output mode with reads that wrap (R7, R8)
    for (int k = 0; k < 5; k++) step(1, dat(6, k), 0, 0, 0);
    for (int k = 0; k < 6; k++) step(1, dat(7, k), 0, 1, 1);
    step(1, dat(7, 9), 0, 1, 0);
    dig[W-1:0] = 64'hDEAD_BEEF_0123_4567;
    for (int k = 0; k < 5; k++) step(1, dat(7, 20 + k), 0, 1, 1);
    for (int k = 5; k < N; k++) step(1, dat(6, k), 0, 0, 0);
    // handoff while in output mode (R5)
    step(0, '0, 0, 1, 1);
    step(1, dat(8, 0), 1, 1, 0);
    step(0, '0, 1, 0, 0);
    step(1, dat(8, 0), 0, 0, 0);
    step(0, '0, 0, 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule